// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Controller

This block watches eight digital inputs and turns their activity into one interrupt request line per channel. Each input first passes through a two-flop synchronizer. Edge detection then compares the synchronized value with the sample taken one cycle earlier. A channel runs in one of two modes. In edge mode, sticky latches record rising and falling transitions. In level mode, the request follows the current input level against a selectable active polarity.

Software reaches the block through a small word-addressed register bus. Through it, software selects the mode of each channel and programs two enable vectors. Each vector can be written whole or changed through its own write-only set and clear aliases. Software can also read and clear the sticky edge latches and read a status word that mirrors the request vector. In edge mode, the second enable vector enables falling edges. In level mode, the same bits choose the active level. A write of ones to the status word clears both latches of an edge channel and inverts the active level of a level channel.

Top module: `pinirq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero and `irq_req` is zero.
- R2: A channel in edge mode (mode bit 0) requests an interrupt once its rising latch is set while its rise/level enable bit is 1.
- R3: A channel in edge mode requests an interrupt once its falling latch is set while its fall/polarity bit is 1.
- R4: The rising and falling detect latches are sticky. A latch stays 1 after its input returns. Writing 1 to a bit at the detect word clears that latch, and writing 0 leaves it unchanged.
- R5: Writing 1 to a bit of a set alias sets that enable bit, and writing 1 to a bit of a clear alias clears it. Zero bits have no effect, and an alias reads as zero.
- R6: A channel in level mode (mode bit 1) requests an interrupt while its rise/level enable bit is 1 and its synchronized input equals the active level. A fall/polarity bit of 0 means active low and 1 means active high.
- R7: Writing 1 to a status bit of an edge-mode channel clears both its rising and falling latches.
- R8: Writing 1 to a status bit of a level-mode channel inverts its fall/polarity bit.
- R9: If an edge is detected in the same cycle that software clears the matching latch, the latch ends up set.
- R10: The status word reads back the current `irq_req` vector.
- R11: The registers sit at word indices 0 mode, 1 rise/level enable, 2 its set alias, 3 its clear alias, 4 fall/polarity enable, 5 its set alias, 6 its clear alias, 7 rising detect, 8 falling detect and 9 status (byte offset = 4 × index). Indices 10 to 15 read zero and ignore writes. Read data appears on the clock edge after the address.
- R12: A pin transition driven before clock edge 1 sets the edge latch at edge 3, and the resulting request appears at edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous channel inputs |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word index of the register accessed |
| bus_wdata | input | 8 | Write data, one bit per channel |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq_req | output | 8 | Registered interrupt request per channel |

## Verification
Some behaviour is checked by assertions on every cycle. These cover the quiet request vector after reset and the rule that no request appears without an enable bit set in the previous cycle. They also cover the stickiness of the latches between writes, the exact effect of set-alias writes and of status writes on the polarity bits, and the rule that a detected edge always leaves its latch set. Other behaviour can only be shown by the bench's scenarios. These are the request patterns for mixed edge and level channels with different enable and polarity vectors, the four-edge request latency, the same-cycle race between an edge and a clear, and the read-back of every register including unmapped indices.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] IDX_MODE    = 4'd0;
  localparam logic [ADDR_W-1:0] IDX_ENR     = 4'd1;
  localparam logic [ADDR_W-1:0] IDX_ENR_SET = 4'd2;
  localparam logic [ADDR_W-1:0] IDX_ENR_CLR = 4'd3;
  localparam logic [ADDR_W-1:0] IDX_ENF     = 4'd4;
  localparam logic [ADDR_W-1:0] IDX_ENF_SET = 4'd5;
  localparam logic [ADDR_W-1:0] IDX_ENF_CLR = 4'd6;
  localparam logic [ADDR_W-1:0] IDX_RDET    = 4'd7;
  localparam logic [ADDR_W-1:0] IDX_FDET    = 4'd8;
  localparam logic [ADDR_W-1:0] IDX_STAT    = 4'd9;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_async,
  output logic [N-1:0] pin_now,
  output logic [N-1:0] pin_prev
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      pin_now  <= '0;
      pin_prev <= '0;
    end else begin
      meta_q   <= pin_async;
      pin_now  <= meta_q;
      pin_prev <= pin_now;
    end
  end
endmodule

// File: rtl/pinirq_chan.sv
module pinirq_chan (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic lvl_mode,
  input  logic en_rise,
  input  logic en_fall,
  input  logic clr_rise,
  input  logic clr_fall,
  output logic rise_lat,
  output logic fall_lat,
  output logic req
);
  logic saw_rise, saw_fall, req_next;

  assign saw_rise = cur & ~prev;
  assign saw_fall = ~cur & prev;

  always_comb begin
    if (lvl_mode) req_next = (cur == en_fall) & en_rise;
    else          req_next = (rise_lat & en_rise) | (fall_lat & en_fall);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_lat <= 1'b0;
      fall_lat <= 1'b0;
      req      <= 1'b0;
    end else begin
      // a fresh edge wins over a clear in the same cycle
      rise_lat <= (rise_lat & ~clr_rise) | saw_rise;
      fall_lat <= (fall_lat & ~clr_fall) | saw_fall;
      req      <= req_next;
    end
  end
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      rise_lat,
  input  logic [N-1:0]      fall_lat,
  input  logic [N-1:0]      req,
  output logic [N-1:0]      mode,
  output logic [N-1:0]      en_r,
  output logic [N-1:0]      en_f,
  output logic [N-1:0]      clr_r,
  output logic [N-1:0]      clr_f
);
  logic wr_rdet, wr_fdet, wr_stat;

  assign wr_rdet = bus_we && (bus_addr == IDX_RDET);
  assign wr_fdet = bus_we && (bus_addr == IDX_FDET);
  assign wr_stat = bus_we && (bus_addr == IDX_STAT);

  // status writes hit the latches only on edge-mode channels
  assign clr_r = (wr_rdet ? bus_wdata : '0) | (wr_stat ? (bus_wdata & ~mode) : '0);
  assign clr_f = (wr_fdet ? bus_wdata : '0) | (wr_stat ? (bus_wdata & ~mode) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
      en_r <= '0;
      en_f <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        IDX_MODE:    mode <= bus_wdata;
        IDX_ENR:     en_r <= bus_wdata;
        IDX_ENR_SET: en_r <= en_r | bus_wdata;
        IDX_ENR_CLR: en_r <= en_r & ~bus_wdata;
        IDX_ENF:     en_f <= bus_wdata;
        IDX_ENF_SET: en_f <= en_f | bus_wdata;
        IDX_ENF_CLR: en_f <= en_f & ~bus_wdata;
        IDX_STAT:    en_f <= en_f ^ (bus_wdata & mode);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        IDX_MODE: bus_rdata <= mode;
        IDX_ENR:  bus_rdata <= en_r;
        IDX_ENF:  bus_rdata <= en_f;
        IDX_RDET: bus_rdata <= rise_lat;
        IDX_FDET: bus_rdata <= fall_lat;
        IDX_STAT: bus_rdata <= req;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
  import pinirq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  output logic [N-1:0]      irq_req
);
  logic [N-1:0] pin_s, pin_p;
  logic [N-1:0] mode, en_r, en_f, clr_r, clr_f;
  logic [N-1:0] rlat, flat;

  pinirq_sync #(.N(N)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_in),
    .pin_now(pin_s), .pin_prev(pin_p)
  );

  pinirq_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rise_lat(rlat), .fall_lat(flat), .req(irq_req),
    .mode(mode), .en_r(en_r), .en_f(en_f), .clr_r(clr_r), .clr_f(clr_f)
  );

  for (genvar g = 0; g < N; g++) begin : g_chan
    pinirq_chan u_chan (
      .clk(clk), .rst(rst),
      .cur(pin_s[g]), .prev(pin_p[g]),
      .lvl_mode(mode[g]), .en_rise(en_r[g]), .en_fall(en_f[g]),
      .clr_rise(clr_r[g]), .clr_fall(clr_f[g]),
      .rise_lat(rlat[g]), .fall_lat(flat[g]), .req(irq_req[g])
    );
  end
endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk
  import pinirq_pkg::*;
#(
  parameter int N = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      irq_req,
  input logic [N-1:0]      mode,
  input logic [N-1:0]      en_r,
  input logic [N-1:0]      en_f,
  input logic [N-1:0]      rlat,
  input logic [N-1:0]      flat,
  input logic [N-1:0]      pin_s,
  input logic [N-1:0]      pin_p
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: request vector is quiet right after a reset edge
  always @(posedge clk) begin
    if (rst_q) p_reset_idle_r1: assert (irq_req == '0) else $error("irq after reset");
  end

  // R2 / R3: a request needs an enable bit in the cycle before
  p_req_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_req & ~$past(en_r | en_f)) == '0));

  // R4: latches never drop unless a bus write happened
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> (((rlat & $past(rlat)) == $past(rlat)) && ((flat & $past(flat)) == $past(flat))));

  // R5: set alias ORs into the rise/level enable
  p_set_alias_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == IDX_ENR_SET) |=> (en_r == $past(en_r | bus_wdata)));

  // R8: status write inverts polarity only on level channels
  p_stat_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == IDX_STAT) |=> (en_f == $past(en_f ^ (bus_wdata & mode))));

  // R9: a detected rising edge always leaves its latch set
  p_edge_kept_r9: assert property (@(posedge clk) disable iff (rst)
    ((pin_s & ~pin_p) != '0) |=> ((rlat & $past(pin_s & ~pin_p)) == $past(pin_s & ~pin_p)));
endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_req(irq_req), .mode(mode), .en_r(en_r), .en_f(en_f),
  .rlat(rlat), .flat(flat), .pin_s(pin_s), .pin_p(pin_p)
);

// File: tb/pinirq_ctrl_tb.sv
module pinirq_ctrl_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic         bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] irq_req;

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pinirq_ctrl #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .pin_in(pins),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // {mode, en_r, en_f, pins_before, pins_after, expected irq}
  localparam logic [47:0] VEC [7] = '{
    {8'h00, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'h0F},  // R2 rising
    {8'h00, 8'h00, 8'hFF, 8'hFF, 8'hF0, 8'h0F},  // R3 falling
    {8'h00, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'hAA},  // R2 partial enables
    {8'h00, 8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'h33},  // R2 R3 mixed
    {8'hFF, 8'hFF, 8'h00, 8'h00, 8'h0F, 8'hF0},  // R6 active low
    {8'hFF, 8'h3C, 8'hFF, 8'h00, 8'h0F, 8'h0C},  // R6 active high
    {8'hF0, 8'hFF, 8'hF0, 8'h00, 8'h55, 8'h55}   // R2 R6 mixed modes
  };

  initial begin
    logic [N-1:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq_req, 8'h00);
    for (int a = 0; a < 10; a++) begin
      rd(a[3:0], r);
      check("R1 reg", r, 8'h00);
    end

    // table walk: R2 R3 R6 R10
    for (int i = 0; i < 7; i++) begin
      wr(4'd0, VEC[i][47:40]);
      wr(4'd1, VEC[i][39:32]);
      wr(4'd4, VEC[i][31:24]);
      pins = VEC[i][23:16];
      settle();
      wr(4'd7, 8'hFF);
      wr(4'd8, 8'hFF);
      settle();
      pins = VEC[i][15:8];
      settle();
      check("R2/R3/R6 irq", irq_req, VEC[i][7:0]);
      rd(4'd9, r);
      check("R10 status", r, VEC[i][7:0]);
    end

    // R5 aliases
    wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd4, 8'h00);
    pins = 8'h00; settle();
    wr(4'd7, 8'hFF); wr(4'd8, 8'hFF);
    wr(4'd2, 8'h81); rd(4'd1, r); check("R5 set", r, 8'h81);
    wr(4'd2, 8'h00); rd(4'd1, r); check("R5 set zero", r, 8'h81);
    wr(4'd3, 8'h01); rd(4'd1, r); check("R5 clr", r, 8'h80);
    wr(4'd5, 8'h42); wr(4'd6, 8'h40); rd(4'd4, r); check("R5 fall alias", r, 8'h02);
    rd(4'd2, r); check("R5 alias reads 0", r, 8'h00);
    wr(4'd1, 8'h00); wr(4'd4, 8'h00);

    // R4 sticky detects
    pins = 8'h04; settle(); pins = 8'h00; settle();
    rd(4'd7, r); check("R4 rdet sticky", r, 8'h04);
    rd(4'd8, r); check("R4 fdet sticky", r, 8'h04);
    wr(4'd7, 8'h00); rd(4'd7, r); check("R4 write0", r, 8'h04);
    wr(4'd7, 8'h04); rd(4'd7, r); check("R4 clear", r, 8'h00);
    rd(4'd8, r); check("R4 other latch", r, 8'h04);

    // R7 status write on edge channel
    pins = 8'h04; settle();
    wr(4'd1, 8'h04); settle();
    check("R7 irq before", irq_req, 8'h04);
    wr(4'd9, 8'h04); settle();
    rd(4'd7, r); check("R7 rdet", r, 8'h00);
    rd(4'd8, r); check("R7 fdet", r, 8'h00);
    check("R7 irq after", irq_req, 8'h00);
    wr(4'd1, 8'h00); pins = 8'h00; settle();
    wr(4'd7, 8'hFF); wr(4'd8, 8'hFF);

    // R8 level toggle
    wr(4'd0, 8'h01); wr(4'd1, 8'h01); settle();
    check("R8 active low", irq_req, 8'h01);
    wr(4'd9, 8'h01); settle();
    rd(4'd4, r); check("R8 polarity", r, 8'h01);
    check("R8 irq", irq_req, 8'h00);
    wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd4, 8'h00);

    // R9 edge and clear in the same cycle
    pins = 8'h08; settle(); pins = 8'h00; settle();
    @(negedge clk); pins = 8'h08;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 4'd7; bus_wdata = 8'h08;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    rd(4'd7, r); check("R9 edge wins", r, 8'h08);
    pins = 8'h00; settle();
    wr(4'd7, 8'hFF); wr(4'd8, 8'hFF); settle();

    // R12 latency
    wr(4'd1, 8'h02);
    @(negedge clk); pins = 8'h02;
    repeat (3) @(negedge clk);
    check("R12 early", irq_req, 8'h00);
    @(negedge clk);
    check("R12 on time", irq_req, 8'h02);

    // R11 unmapped index
    wr(4'd0, 8'h00);
    wr(4'd12, 8'hFF);
    rd(4'd0, r); check("R11 mode untouched", r, 8'h00);
    rd(4'd1, r); check("R11 enable untouched", r, 8'h02);
    rd(4'd12, r); check("R11 reads zero", r, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule